// File: doc/BRIEF.md
# Receive FIFO Threshold DMA Start Controller

This block decides when the DMA engine may begin moving a received packet from the receive FIFO out to system memory, for traffic flowing from the host toward the device. It watches how many 32-bit words of the current packet have reached the FIFO. It also watches the end-of-packet indication and the packet status, and raises a start/continue request for the DMA.

There are two policies. With early start disabled, the request waits for the whole packet. With early start enabled, the request goes up as soon as the packet's word count reaches a programmed 8-bit quadlet threshold, while the packet may still prove bad. When that happens, a one-cycle error pulse tells the descriptor logic to mark the transfer invalid. Once raised, the request stays up until the DMA reports that the whole packet has been drained.

Top module: `rx_thr_start`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `dmaReq` and `earlyErr` are both 0. Reset is asynchronous and active low.
- R2: With `thrEn` = 0, `dmaReq` stays 0 whatever the value of `rxWordCnt`. It rises in the cycle after `pktEnd` is sampled high.
- R3: With `thrEn` = 1 and no packet in progress, `dmaReq` rises in the cycle after `rxWordCnt` is sampled at or above `thrLen`, before `pktEnd`. Counts below `thrLen` do not raise it. The full range up to `thrLen` = 255 is covered.
- R4: A `thrLen` of 0 acts as a threshold of 1. A count of 0 raises no request, and a count of 1 does.
- R5: If a packet ends before its count reaches the threshold, the request rises in the cycle after `pktEnd`. No error is flagged, even when `pktBad` = 1.
- R6: Once raised, `dmaReq` stays 1 until `drainDone` is sampled high after the packet has ended. It drops in the following cycle. A `drainDone` pulse before `pktEnd` has no effect.
- R7: After an early start, a `pktEnd` sampled with `pktBad` = 1 makes `earlyErr` 1 for exactly the next cycle, while `dmaReq` is 1.
- R8: After an early start, a `pktEnd` sampled with `pktBad` = 0 leaves `earlyErr` at 0.
- R9: When the threshold is reached in the same cycle as `pktEnd`, the packet counts as complete rather than early. The request rises and no error is flagged, even with `pktBad` = 1.
- R10: With `thrEn` = 0, a bad packet never raises `earlyErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| thrEn | input | 1 | 1 enables early start on a word threshold |
| thrLen | input | 8 | Threshold in 32-bit words; 0 acts as 1 |
| rxWordCnt | input | 11 | Words of the current packet written to the FIFO so far |
| pktEnd | input | 1 | Pulse: the current packet is complete in the FIFO |
| pktBad | input | 1 | Packet status, valid with `pktEnd`; 1 means bad |
| drainDone | input | 1 | Pulse: DMA has drained the ended packet |
| dmaReq | output | 1 | DMA start/continue request |
| earlyErr | output | 1 | One-cycle pulse: bad packet after early start |

## Verification
Two functions can fall in the same cycle: the threshold being reached and the packet ending. The stimulus table presents a packet whose count meets the threshold on exactly the cycle where `pktEnd` arrives with a bad status. The check expects the request to rise with no error pulse. The next row then sends `drainDone` and expects the request to drop, which it would not if the controller had wrongly taken the early path. A short bad packet, and a bad packet with early start disabled, separate the error path from the ordinary end-of-packet path.

// File: rtl/rx_thr_pkg.sv
package rx_thr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic markEarly;
    logic fireErr;
  } ctlStrobe_t;

endpackage

// File: rtl/rx_thr_dp.sv
module rx_thr_dp
  import rx_thr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             thrEn,
  input  logic [THR_W-1:0] thrLen,
  input  logic [CNT_W-1:0] rxWordCnt,
  input  logic             pktEnd,
  input  ctlStrobe_t       strobe,
  output logic             thrHit,
  output logic             dmaReq,
  output logic             earlyErr
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] effThr;
  logic [CMP_W-1:0] cntExt;
  logic             earlyFlag;

  // Zero threshold behaves as one word
  always_comb begin
    effThr = CMP_W'(thrLen);
    if (thrLen == '0) effThr = CMP_W'(1);
    cntExt = CMP_W'(rxWordCnt);
    thrHit = thrEn && (cntExt >= effThr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaReq    <= 1'b0;
      earlyFlag <= 1'b0;
      earlyErr  <= 1'b0;
    end else begin
      if (strobe.setReq)         dmaReq <= 1'b1;
      else if (strobe.clrReq)    dmaReq <= 1'b0;
      if (strobe.markEarly)      earlyFlag <= 1'b1;
      else if (strobe.clrReq)    earlyFlag <= 1'b0;
      earlyErr <= strobe.fireErr;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !strobe.clrReq) |=> dmaReq); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    earlyErr |=> !earlyErr); // R7

  AST_ERR_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    earlyErr |-> dmaReq); // R7

  AST_ERR_NEEDS_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fireErr |-> earlyFlag); // R5

  AST_DISABLED_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && !thrEn && !pktEnd) |=> !dmaReq); // R2

endmodule

// File: rtl/rx_thr_ctl.sv
module rx_thr_ctl
  import rx_thr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       thrHit,
  input  logic       pktEnd,
  input  logic       pktBad,
  input  logic       drainDone,
  output ctlStrobe_t strobe
);

  ctlState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        // A complete packet wins over a threshold hit in the same cycle
        if (pktEnd) begin
          strobe.setReq = 1'b1;
          stateNxt      = ST_DRAIN;
        end else if (thrHit) begin
          strobe.setReq    = 1'b1;
          strobe.markEarly = 1'b1;
          stateNxt         = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (pktEnd) begin
          strobe.fireErr = pktBad;
          stateNxt       = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (drainDone) begin
          strobe.clrReq = 1'b1;
          stateNxt      = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_ACTIVE_IGNORES_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !pktEnd) |=> (state == ST_ACTIVE)); // R6

  AST_SAME_CYCLE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pktEnd) |=> (state == ST_DRAIN)); // R9

endmodule

// File: rtl/rx_thr_start.sv
module rx_thr_start
  import rx_thr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             thrEn,
  input  logic [THR_W-1:0] thrLen,
  input  logic [CNT_W-1:0] rxWordCnt,
  input  logic             pktEnd,
  input  logic             pktBad,
  input  logic             drainDone,
  output logic             dmaReq,
  output logic             earlyErr
);

  ctlStrobe_t strobe;
  logic       thrHit;

  rx_thr_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .thrHit    (thrHit),
    .pktEnd    (pktEnd),
    .pktBad    (pktBad),
    .drainDone (drainDone),
    .strobe    (strobe)
  );

  rx_thr_dp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .thrEn     (thrEn),
    .thrLen    (thrLen),
    .rxWordCnt (rxWordCnt),
    .pktEnd    (pktEnd),
    .strobe    (strobe),
    .thrHit    (thrHit),
    .dmaReq    (dmaReq),
    .earlyErr  (earlyErr)
  );

endmodule

// File: tb/tb_rx_thr_start.sv
module tb_rx_thr_start;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        thrEn = 1'b0;
  logic [7:0]  thrLen = 8'd0;
  logic [10:0] rxWordCnt = 11'd0;
  logic        pktEnd = 1'b0;
  logic        pktBad = 1'b0;
  logic        drainDone = 1'b0;
  logic        dmaReq;
  logic        earlyErr;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  rx_thr_start dut (
    .clk(clk), .rstN(rstN), .thrEn(thrEn), .thrLen(thrLen),
    .rxWordCnt(rxWordCnt), .pktEnd(pktEnd), .pktBad(pktBad),
    .drainDone(drainDone), .dmaReq(dmaReq), .earlyErr(earlyErr)
  );

  // [28:25] req tag, [24] en, [23:16] len, [15:5] cnt, [4] end, [3] bad, [2] drain, [1] expReq, [0] expErr
  localparam int NV = 24;
  localparam logic [28:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'd4, 11'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 below anything, disabled
    {4'd2, 1'b0, 8'd4, 11'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 above threshold, still waits
    {4'd2, 1'b0, 8'd4, 11'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 packet end raises request
    {4'd6, 1'b0, 8'd4, 11'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 held
    {4'd6, 1'b0, 8'd4, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 drain drops it
    {4'd3, 1'b1, 8'd3, 11'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 below threshold
    {4'd3, 1'b1, 8'd3, 11'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 at threshold
    {4'd6, 1'b1, 8'd3, 11'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 early drain ignored
    {4'd7, 1'b1, 8'd3, 11'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R7 bad end flags
    {4'd7, 1'b1, 8'd3, 11'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 one cycle only
    {4'd6, 1'b1, 8'd3, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {4'd3, 1'b1, 8'd3, 11'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3
    {4'd8, 1'b1, 8'd3, 11'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R8 good end no flag
    {4'd6, 1'b1, 8'd3, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {4'd5, 1'b1, 8'd8, 11'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 short bad packet
    {4'd5, 1'b1, 8'd8, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    {4'd4, 1'b1, 8'd0, 11'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 zero words
    {4'd4, 1'b1, 8'd0, 11'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 one word starts
    {4'd4, 1'b1, 8'd0, 11'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4
    {4'd6, 1'b1, 8'd0, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {4'd9, 1'b1, 8'd4, 11'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R9 hit and end together
    {4'd9, 1'b1, 8'd4, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 drain accepted
    {4'd10, 1'b0, 8'd4, 11'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R10 disabled bad packet
    {4'd10, 1'b0, 8'd4, 11'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}  // R10
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: {dmaReq,earlyErr} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic en, input logic [7:0] len, input logic [10:0] cnt,
                       input logic e, input logic b, input logic d);
    thrEn = en; thrLen = len; rxWordCnt = cnt; pktEnd = e; pktBad = b; drainDone = d;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    #1;
    chk("R1 in reset", {dmaReq, earlyErr}, 2'b00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {dmaReq, earlyErr}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24], VEC[i][23:16], VEC[i][15:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      @(negedge clk);
      chk($sformatf("R%0d row %0d", VEC[i][28:25], i), {dmaReq, earlyErr}, VEC[i][1:0]);
    end

    // R3 top of the threshold range
    drive(1'b1, 8'd255, 11'd254, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 count 254 of 255", {dmaReq, earlyErr}, 2'b00);
    drive(1'b1, 8'd255, 11'd255, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 count 255 of 255", {dmaReq, earlyErr}, 2'b10);
    drive(1'b1, 8'd255, 11'd300, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 good end after 255", {dmaReq, earlyErr}, 2'b10);

    // R1 reset while a request is held
    drive(1'b0, 8'd0, 11'd0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b0;
    #1;
    chk("R1 reset clears request", {dmaReq, earlyErr}, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {dmaReq, earlyErr}, 2'b00);

    finishRun();
  end

endmodule